// File: doc/BRIEF.md
# Serial channel baud clock generator

This block produces the sampling clock for one asynchronous serial channel. Three single-cycle clock-enable inputs stand in for the possible timing sources: the master clock, the channel's receive/transmit pin clock (pin A) and the channel's bidirectional pin clock (pin B). A small write-only register port holds a 16-bit time constant and a control word. The control word picks the source, picks the division path and turns the generator on.

There are two division paths. The direct prescaler emits one 16x sample tick for every 1, 2 or 4 pin-clock ticks, which gives bit rates of the pin clock divided by 16, 32 or 64. The reloadable generator counts N+2 source ticks per half period and changes its output level at each terminal count. This yields one 16x tick every 2*(N+2) source ticks. A bit tick accompanies every sixteenth 16x tick.

The block runs a three-state controller. IDLE holds all counters at their load values. RUN counts source ticks. FAULT is entered on an illegal source/path pairing and keeps both outputs silent. Transitions: IDLE→RUN when enabled with a legal pairing; IDLE→FAULT when enabled with an illegal pairing; RUN→IDLE when disabled; RUN→FAULT when the pairing becomes illegal while enabled; FAULT→IDLE when disabled.

Top module: `baud_clock_gen`

## Requirements
- R1: After reset, `x16_tick_o`, `bit_tick_o` and `cfg_err_o` are low and the block is disabled.
- R2: A write with `cfg_addr_i`=0 stores `cfg_wdata_i` as the time constant N. A write with `cfg_addr_i`=1 stores the control word: bit 0 is enable; bits 2:1 are the source (0 master, 1 pin A, 2 pin B, 3 none); bits 4:3 are the path (0 generator, 1 divide-by-16, 2 divide-by-32, 3 divide-by-64).
- R3: On the generator path with time constant N, `x16_tick_o` pulses for one cycle, one cycle after every 2*(N+2)-th selected source tick counted from enable, and at no other time.
- R4: The generator path is legal only with the master or pin A source.
- R5: The divide-by-16, -32 and -64 paths pulse `x16_tick_o` one cycle after every 1st, 2nd and 4th selected source tick, counted from enable.
- R6: The direct paths are legal only with pin A or pin B. A direct path with the master source is illegal, and source 3 is illegal on every path.
- R7: An enabled illegal pairing sets `cfg_err_o`, which stays high until reset. While that pairing stands, both ticks stay low. Disabling and then enabling with a legal pairing restores the ticks.
- R8: `bit_tick_o` pulses together with every 16th `x16_tick_o` pulse counted from enable, and never without it.
- R9: A time-constant write during RUN takes effect at the next reload. While disabled, the counters track the stored constant, so an enable starts from it at once.
- R10: Re-enabling restarts both the division count and the bit count from zero.
- R11: Ticks on unselected sources have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register select: 0 time constant, 1 control |
| cfg_wdata_i | input | 16 | Write data |
| tick_mst_i | input | 1 | Master clock enable tick |
| tick_pa_i | input | 1 | Pin A (receive/transmit pin) clock tick |
| tick_pb_i | input | 1 | Pin B (bidirectional pin) clock tick |
| x16_tick_o | output | 1 | 16x sample tick |
| bit_tick_o | output | 1 | One-per-bit tick |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The hardest case to reach is a time-constant change in the middle of a running half period. The new value must be picked up at the reload and not earlier. The bench places the write between two known source ticks and predicts the shifted pulse positions by hand. Stale counter state from an aborted run is reached by stopping a run partway through a bit and then re-enabling. The full period sweeps carry ticks on the unselected sources in every gap cycle.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    typedef enum logic [1:0] {
        SRC_MASTER = 2'd0,
        SRC_PIN_A  = 2'd1,
        SRC_PIN_B  = 2'd2,
        SRC_NONE   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        PATH_GEN   = 2'd0,
        PATH_DIV16 = 2'd1,
        PATH_DIV32 = 2'd2,
        PATH_DIV64 = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } state_e;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_gen_pkg::*;
#(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic            addr_i,
    input  logic [TC_W-1:0] wdata_i,
    output logic [TC_W-1:0] tc_o,
    output logic            en_o,
    output src_e            src_o,
    output path_e           path_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_o   <= '0;
            en_o   <= 1'b0;
            src_o  <= SRC_MASTER;
            path_o <= PATH_GEN;
        end else if (we_i) begin
            if (!addr_i) begin
                tc_o <= wdata_i;
            end else begin
                en_o   <= wdata_i[0];
                src_o  <= src_e'(wdata_i[2:1]);
                path_o <= path_e'(wdata_i[4:3]);
            end
        end
    end

    assert_tc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !addr_i) |=> (tc_o == $past(wdata_i)));
endmodule

// File: rtl/baud_brg.sv
module baud_brg #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [TC_W-1:0] tc_i,
    output logic            pulse_o
);
    localparam int CNT_W = TC_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic [CNT_W-1:0] reload;

    assign reload  = {1'b0, tc_i} + CNT_W'(1);
    assign pulse_o = step_i && (cnt_q == '0) && !phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else if (load_i) begin
            cnt_q   <= reload;
            phase_q <= 1'b1;
        end else if (step_i) begin
            if (cnt_q == '0) begin
                cnt_q   <= reload;
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assert_phase_on_terminal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> ($past(load_i) || ($past(step_i) && $past(cnt_q) == '0)));
endmodule

// File: rtl/baud_presc.sv
module baud_presc
    import baud_gen_pkg::*;
#(
    parameter int DC_W = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  step_i,
    input  path_e path_i,
    output logic  pulse_o
);
    logic [DC_W-1:0] dc_q;
    logic [DC_W-1:0] limit;

    always_comb begin
        unique case (path_i)
            PATH_DIV32: limit = DC_W'(1);
            PATH_DIV64: limit = DC_W'(3);
            default:    limit = '0;
        endcase
    end

    assign pulse_o = step_i && (dc_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            dc_q <= '0;
        end else if (step_i) begin
            dc_q <= (dc_q >= limit) ? '0 : dc_q + DC_W'(1);
        end
    end

    assert_presc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !$past(load_i) && $stable(path_i)) |-> (dc_q <= limit));
endmodule

// File: rtl/bit_tick_ctr.sv
module bit_tick_ctr #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic pulse_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(OVS);

    logic [CNT_W-1:0] cnt_q;

    assign last_o = pulse_i && (cnt_q == CNT_W'(OVS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            cnt_q <= '0;
        end else if (pulse_i) begin
            cnt_q <= (cnt_q == CNT_W'(OVS - 1)) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    assert_last_needs_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> pulse_i);
endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen
    import baud_gen_pkg::*;
#(
    parameter int TC_W = 16,
    parameter int OVS  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic            cfg_addr_i,
    input  logic [TC_W-1:0] cfg_wdata_i,
    input  logic            tick_mst_i,
    input  logic            tick_pa_i,
    input  logic            tick_pb_i,
    output logic            x16_tick_o,
    output logic            bit_tick_o,
    output logic            cfg_err_o
);
    logic [TC_W-1:0] tc;
    logic            en;
    src_e            src;
    path_e           path;
    state_e          state_q, state_d;
    logic            sel_tick, legal, running, load;
    logic            gen_step, div_step, gen_pulse, div_pulse, x16_pulse, bit_last;

    baud_cfg_regs #(.TC_W(TC_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .tc_o(tc), .en_o(en), .src_o(src), .path_o(path)
    );

    always_comb begin
        unique case (src)
            SRC_MASTER: sel_tick = tick_mst_i;
            SRC_PIN_A:  sel_tick = tick_pa_i;
            SRC_PIN_B:  sel_tick = tick_pb_i;
            default:    sel_tick = 1'b0;
        endcase
    end

    always_comb begin
        if (path == PATH_GEN) legal = (src == SRC_MASTER) || (src == SRC_PIN_A);
        else                  legal = (src == SRC_PIN_A) || (src == SRC_PIN_B);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = legal ? ST_RUN : ST_FAULT;
            ST_RUN:   if (!en) state_d = ST_IDLE;
                      else if (!legal) state_d = ST_FAULT;
            ST_FAULT: if (!en) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign running  = (state_q == ST_RUN) && en && legal;
    assign load     = (state_q != ST_RUN);
    assign gen_step = running && sel_tick && (path == PATH_GEN);
    assign div_step = running && sel_tick && (path != PATH_GEN);

    baud_brg #(.TC_W(TC_W)) brg_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(gen_step),
        .tc_i(tc), .pulse_o(gen_pulse)
    );

    baud_presc #(.DC_W(2)) presc_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(div_step),
        .path_i(path), .pulse_o(div_pulse)
    );

    assign x16_pulse = (path == PATH_GEN) ? gen_pulse : div_pulse;

    bit_tick_ctr #(.OVS(OVS)) bits_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .pulse_i(x16_pulse),
        .last_o(bit_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x16_tick_o <= 1'b0;
            bit_tick_o <= 1'b0;
            cfg_err_o  <= 1'b0;
        end else begin
            x16_tick_o <= x16_pulse;
            bit_tick_o <= bit_last;
            cfg_err_o  <= cfg_err_o || (state_d == ST_FAULT);
        end
    end

    assert_bit_with_x16_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> x16_tick_o);
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);
    assert_quiet_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> (!x16_tick_o && !bit_tick_o));
    assert_quiet_not_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> !x16_tick_o);
    assert_fault_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |-> cfg_err_o);
endmodule

// File: tb/baud_clock_gen_tb.sv
module baud_clock_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_addr_i = 1'b0;
    logic [15:0] cfg_wdata_i = '0;
    logic        tick_mst_i = 1'b0, tick_pa_i = 1'b0, tick_pb_i = 1'b0;
    logic        x16_tick_o, bit_tick_o, cfg_err_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    baud_clock_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .tick_mst_i(tick_mst_i), .tick_pa_i(tick_pa_i),
        .tick_pb_i(tick_pb_i), .x16_tick_o(x16_tick_o), .bit_tick_o(bit_tick_o),
        .cfg_err_o(cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit addr, input int data);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = addr; cfg_wdata_i = 16'(data);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic set_ticks(input int src, input bit sel, input bit others);
        tick_mst_i = (src == 0) ? sel : others;
        tick_pa_i  = (src == 1) ? sel : others;
        tick_pb_i  = (src == 2) ? sel : others;
        if (src == 3) begin
            tick_mst_i = sel; tick_pa_i = sel; tick_pb_i = sel;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start(input int src, input int path, input int n);
        wr(1'b1, (path << 3) | (src << 1));
        wr(1'b0, n);
        wr(1'b1, (path << 3) | (src << 1) | 1);
        @(negedge clk);
    endtask

    // Feeds one selected tick followed by one gap cycle with ticks on the other sources;
    // returns the outputs seen after the tick and after the gap.
    task automatic step(input int src, output bit x16, output bit bt, output bit gap_any);
        set_ticks(src, 1'b1, 1'b0);
        @(negedge clk);
        x16 = x16_tick_o; bt = bit_tick_o;
        set_ticks(src, 1'b0, 1'b1);
        @(negedge clk);
        gap_any = x16_tick_o || bit_tick_o;
        set_ticks(src, 1'b0, 1'b0);
    endtask

    task automatic run_cfg(input int src, input int path, input int n, input int ticks,
                           input string req);
        int  k;
        int  bad;
        int  pulses;
        int  bits;
        bit  x, b, g;
        k = (path == 0) ? 2 * (n + 2) : (1 << (path - 1));
        bad = 0; pulses = 0; bits = 0;
        start(src, path, n);
        for (int i = 1; i <= ticks; i++) begin
            step(src, x, b, g);
            if (x) pulses++;
            if (b) bits++;
            if (x != (i % k == 0) || b != (i % (16 * k) == 0) || g) begin
                if (bad == 0)
                    $display("  mismatch %s tick %0d: x16=%0d bit=%0d gap=%0d (period %0d)",
                             req, i, x, b, g, k);
                bad++;
            end
        end
        check(bad == 0, req, bad, 0);
        check(pulses == ticks / k, {req, " pulse count"}, pulses, ticks / k);
        check(bits == ticks / (16 * k), "R8 bit count", bits, ticks / (16 * k));
    endtask

    task automatic run_illegal(input int src, input int path, input string req);
        int any;
        bit x, b, g;
        any = 0;
        start(src, path, 0);
        for (int i = 0; i < 40; i++) begin
            step(src, x, b, g);
            if (x || b || g) any++;
        end
        check(any == 0, {req, " ticks quiet"}, any, 0);
        check(cfg_err_o == 1'b1, {req, " err set"}, cfg_err_o, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit x, b, g;
        int hits;
        int pos [3];
        int np;
        do_reset();
        // R1 reset state
        check(x16_tick_o == 0 && bit_tick_o == 0, "R1 ticks low", x16_tick_o, 0);
        check(cfg_err_o == 0, "R1 err low", cfg_err_o, 0);

        // R3/R4/R11: generator sweep from master and pin A, with noise on other sources
        for (int n = 0; n <= 5; n++) run_cfg(0, 0, n, 32 * (n + 2) * 2, "R3 gen master");
        for (int n = 0; n <= 3; n++) run_cfg(1, 0, n, 32 * (n + 2) * 2, "R4 gen pinA");
        run_cfg(0, 0, 200, 2 * 404, "R3 gen large N");

        // R5/R6: direct paths from both pin sources
        for (int s = 1; s <= 2; s++)
            for (int p = 1; p <= 3; p++)
                run_cfg(s, p, 0, 32 * (1 << (p - 1)), "R5 direct");
        check(cfg_err_o == 0, "R6 legal pairs leave err low", cfg_err_o, 0);

        // R9: time-constant change mid-count (N=3 then N=1 -> pulses at 8,14,20)
        start(0, 0, 3);
        np = 0; hits = 0;
        for (int i = 1; i <= 20; i++) begin
            if (i == 4) wr(1'b0, 1);
            step(0, x, b, g);
            if (x) begin
                if (np < 3) pos[np] = i;
                np++;
            end
        end
        check(np == 3, "R9 pulse count after update", np, 3);
        check(pos[0] == 8, "R9 first pulse", pos[0], 8);
        check(pos[1] == 14 && pos[2] == 20, "R9 later pulses", pos[2], 20);

        // R10: abort partway through a bit, then restart cleanly
        start(1, 0, 2);
        for (int i = 0; i < 37; i++) step(1, x, b, g);
        run_cfg(1, 0, 2, 256, "R10 restart");

        // R4/R6/R7: illegal pairings
        run_illegal(2, 0, "R4 gen pinB");
        for (int p = 1; p <= 3; p++) run_illegal(0, p, "R6 direct master");
        run_illegal(3, 2, "R6 no source");
        run_cfg(2, 1, 0, 48, "R7 recovery");
        check(cfg_err_o == 1, "R7 err sticky", cfg_err_o, 1);

        // R7: illegal change while running
        start(1, 0, 1);
        for (int i = 0; i < 5; i++) step(1, x, b, g);
        wr(1'b1, (0 << 3) | (2 << 1) | 1);
        hits = 0;
        for (int i = 0; i < 30; i++) begin
            step(2, x, b, g);
            if (x || b || g) hits++;
        end
        check(hits == 0, "R7 quiet after live illegal change", hits, 0);

        // R1: reset clears err
        do_reset();
        check(cfg_err_o == 0, "R1 err cleared by reset", cfg_err_o, 0);
        // R2: control encodings recheck after reset
        run_cfg(1, 3, 0, 64, "R2 encoding div64 pinA");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule